// File: doc/BRIEF.md
# LCD Controller Register File

This block is the software-visible configuration store of a colour LCD controller. It sits behind a 32-bit memory-mapped port that decodes a 4 KB byte window. It holds four display timing words, the base addresses of the upper and lower panel frame buffers, a control word, an interrupt mask and a sticky event status. Eight read-only words at the top of the window return identification bytes. Accesses to the palette sub-window at byte offsets 0x200 to 0x3FF are passed straight to a separate palette block.

From the stored words the block derives the active column count, the active row count, a three-bit pixel depth code and a display enable. It also raises an interrupt line from the masked status. Event logic outside the block reports status events through a per-cycle set vector. Any accepted register write produces a one-cycle configuration-changed pulse, so that the downstream engine knows to reload its settings.

A variant parameter selects between the base register layout and the derived layouts. The derived layouts exchange the addresses of the mask and control words. The extended variant also reports different identification bytes.

Top module: `lcd_regs`

## Requirements
- R1: After reset every stored word reads 0. Byte offsets 0x00, 0x04, 0x08 and 0x0C hold timing words 0 to 3, 0x10 holds the upper base and 0x14 holds the lower base. Each of these reads back the last value written. A read returns its data on `bus_rdata` one clock after the cycle in which `bus_rd` is high.
- R2: `cols` equals ((timing0 AND 0xFC) + 4) × 4, so 16 after reset and 1024 at most.
- R3: `rows` equals (timing1 AND 0x3FF) + 1, so 1 after reset and 1024 at most.
- R4: `depth` equals control bits [3:1].
- R5: `disp_en` is high only when control bit 0 and control bit 11 are both 1.
- R6: With VARIANT = 0, byte offset 0x18 is the mask and 0x1C is the control word. With VARIANT = 1 or 2, the two offsets are exchanged for both reads and writes.
- R7: Offset 0x20 reads the raw status and 0x24 reads status AND mask. Both are zero-extended from NEVT bits, and the mask also reads back zero-extended.
- R8: A write to offset 0x28 clears every status bit whose write-data bit is 1. A bit set by `evt_set` in the same cycle stays set.
- R9: `irq` is the OR of all status bits that are also set in the mask.
- R10: Offsets 0x2C and 0x30 read the current upper and lower base addresses.
- R11: Offsets 0xFE0 to 0xFFC each read one identification byte in bits [7:0]. For variants 0 and 1 the bytes are 10,11,04,00,0D,F0,05,B1 (hex). For variant 2 they are 11,11,24,00,0D,F0,05,B1.
- R12: Reads of unmapped offsets (0x34 to 0x1FC, 0x400 to 0xFDC, and the write-only 0x28) return 0. Writes to unmapped or read-only offsets change no state and give no pulse.
- R13: For byte offsets 0x200 to 0x3FC, `pal_we` and `pal_re` follow `bus_wr` and `bus_rd` in the same cycle, with `pal_idx` = address bits [8:2] and `pal_wdata` = `bus_wdata`. A read returns `pal_rdata` on the next cycle.
- R14: `cfg_changed` is high for exactly the cycle after any write to a writable offset, including the clear and palette offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| evt_set | input | NEVT | Per-cycle status set vector |
| irq | output | 1 | Masked status OR |
| pal_we | output | 1 | Palette write strobe |
| pal_re | output | 1 | Palette read strobe |
| pal_idx | output | 7 | Palette word index |
| pal_wdata | output | DW | Palette write data |
| pal_rdata | input | DW | Palette read data |
| cols | output | 11 | Active columns |
| rows | output | 11 | Active rows |
| depth | output | 3 | Pixel depth code |
| disp_en | output | 1 | Display enable |
| cfg_changed | output | 1 | One-cycle write pulse |

## Verification
Read data is due one clock after the strobe cycle. The bench records each read request at the rising edge and compares the queued expectation at the following falling edge. The derived outputs (`cols`, `rows`, `depth`, `disp_en`, `irq`) and the `cfg_changed` pulse settle in the cycle after the write or event edge, so each is sampled at the falling edge right after the strobe is removed. Palette strobes are combinational and are sampled in the same cycle in which the access is driven.

// File: rtl/lcd_regs_pkg.sv
package lcd_regs_pkg;

   localparam int ADDR_W = 12;
   localparam int WORD_W = ADDR_W - 2;
   localparam int PAL_IW = 7;
   localparam int NTIM   = 4;
   localparam int COLS_W = 11;
   localparam int ROWS_W = 11;
   localparam int DEPTH_W = 3;
   localparam int CTRL_EN_BIT  = 0;
   localparam int CTRL_PWR_BIT = 11;
   localparam int CTRL_DEPTH_LSB = 1;

   typedef enum logic [3:0] {
      SEL_NONE, SEL_TIM0, SEL_TIM1, SEL_TIM2, SEL_TIM3,
      SEL_UPB, SEL_LPB, SEL_MASK, SEL_CTRL, SEL_RAW,
      SEL_MSKD, SEL_CLR, SEL_UPCUR, SEL_LPCUR, SEL_PAL, SEL_ID
   } reg_sel_e;

   function automatic logic [7:0] id_byte(input int variant, input logic [2:0] idx);
      logic [7:0] b;
      case (idx)
         3'd0:    b = (variant == 2) ? 8'h11 : 8'h10;
         3'd1:    b = 8'h11;
         3'd2:    b = (variant == 2) ? 8'h24 : 8'h04;
         3'd3:    b = 8'h00;
         3'd4:    b = 8'h0D;
         3'd5:    b = 8'hF0;
         3'd6:    b = 8'h05;
         default: b = 8'hB1;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/lcd_regs_decode.sv
module lcd_regs_decode
   import lcd_regs_pkg::*;
#(
   parameter int SWAP = 0
)(
   input  logic [WORD_W-1:0] word,
   output reg_sel_e          sel,
   output logic [2:0]        id_idx,
   output logic [PAL_IW-1:0] pal_idx
);

   reg_sel_e w6_sel, w7_sel;

   generate
      if (SWAP != 0) begin : g_swapped
         assign w6_sel = SEL_CTRL;
         assign w7_sel = SEL_MASK;
      end else begin : g_plain
         assign w6_sel = SEL_MASK;
         assign w7_sel = SEL_CTRL;
      end
   endgenerate

   assign id_idx  = word[2:0];
   assign pal_idx = word[PAL_IW-1:0];

   always_comb begin
      sel = SEL_NONE;
      if (word >= WORD_W'(10'h3F8)) begin
         sel = SEL_ID;
      end else if (word[WORD_W-1:PAL_IW] == 3'b001) begin
         sel = SEL_PAL;
      end else if (word[WORD_W-1:4] == '0) begin
         case (word[3:0])
            4'd0:    sel = SEL_TIM0;
            4'd1:    sel = SEL_TIM1;
            4'd2:    sel = SEL_TIM2;
            4'd3:    sel = SEL_TIM3;
            4'd4:    sel = SEL_UPB;
            4'd5:    sel = SEL_LPB;
            4'd6:    sel = w6_sel;
            4'd7:    sel = w7_sel;
            4'd8:    sel = SEL_RAW;
            4'd9:    sel = SEL_MSKD;
            4'd10:   sel = SEL_CLR;
            4'd11:   sel = SEL_UPCUR;
            4'd12:   sel = SEL_LPCUR;
            default: sel = SEL_NONE;
         endcase
      end
   end

endmodule

// File: rtl/lcd_regs_irq.sv
module lcd_regs_irq #(
   parameter int NEVT = 5
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mask_we,
   input  logic            clr_we,
   input  logic [NEVT-1:0] wr_bits,
   input  logic [NEVT-1:0] evt_set,
   output logic [NEVT-1:0] status,
   output logic [NEVT-1:0] mask,
   output logic            irq
);

   logic [NEVT-1:0] kept;

   assign kept = clr_we ? (status & ~wr_bits) : status;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
         mask   <= '0;
      end else begin
         status <= kept | evt_set;
         if (mask_we) mask <= wr_bits;
      end
   end

   assign irq = |(status & mask);

   p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_set != '0) |=> ((status & $past(evt_set)) == $past(evt_set)));

   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((status & $past(wr_bits & ~evt_set)) == '0));

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_we && evt_set == '0) |=> $stable(status));

   p_no_mask_no_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |-> !irq);

endmodule

// File: rtl/lcd_regs_geom.sv
module lcd_regs_geom
   import lcd_regs_pkg::*;
(
   input  logic [5:0]         tim0_ppl,
   input  logic [9:0]         tim1_lpp,
   input  logic [DEPTH_W-1:0] ctrl_depth,
   input  logic               ctrl_en,
   input  logic               ctrl_pwr,
   output logic [COLS_W-1:0]  cols,
   output logic [ROWS_W-1:0]  rows,
   output logic [DEPTH_W-1:0] depth,
   output logic               disp_en
);

   // (field*4 + 4) * 4 is (field + 1) * 16
   assign cols    = (COLS_W'(tim0_ppl) + COLS_W'(1)) << 4;
   assign rows    = ROWS_W'(tim1_lpp) + ROWS_W'(1);
   assign depth   = ctrl_depth;
   assign disp_en = ctrl_en & ctrl_pwr;

endmodule

// File: rtl/lcd_regs.sv
module lcd_regs
   import lcd_regs_pkg::*;
#(
   parameter int DW      = 32,
   parameter int NEVT    = 5,
   parameter int VARIANT = 0
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DW-1:0]      bus_wdata,
   output logic [DW-1:0]      bus_rdata,
   input  logic [NEVT-1:0]    evt_set,
   output logic               irq,
   output logic               pal_we,
   output logic               pal_re,
   output logic [PAL_IW-1:0]  pal_idx,
   output logic [DW-1:0]      pal_wdata,
   input  logic [DW-1:0]      pal_rdata,
   output logic [COLS_W-1:0]  cols,
   output logic [ROWS_W-1:0]  rows,
   output logic [DEPTH_W-1:0] depth,
   output logic               disp_en,
   output logic               cfg_changed
);

   localparam int SWAP = (VARIANT != 0) ? 1 : 0;
   localparam reg_sel_e TIM_SEL [NTIM] = '{SEL_TIM0, SEL_TIM1, SEL_TIM2, SEL_TIM3};

   generate
      if (VARIANT < 0 || VARIANT > 2) begin : g_bad_variant
         $error("lcd_regs: VARIANT must be 0, 1 or 2");
      end
      if (DW < 16) begin : g_bad_dw
         $error("lcd_regs: DW must hold control bit 11");
      end
      if (NEVT < 1 || NEVT > DW) begin : g_bad_nevt
         $error("lcd_regs: NEVT out of range");
      end
   endgenerate

   reg_sel_e        sel;
   logic [2:0]      id_idx;
   logic [DW-1:0]   tim_q [NTIM];
   logic [DW-1:0]   upb_q, lpb_q, ctrl_q;
   logic [NEVT-1:0] status, mask;
   logic [DW-1:0]   rd_d;
   logic            writable;

   lcd_regs_decode #(.SWAP(SWAP)) u_decode (
      .word    (bus_addr[ADDR_W-1:2]),
      .sel     (sel),
      .id_idx  (id_idx),
      .pal_idx (pal_idx)
   );

   generate
      for (genvar g = 0; g < NTIM; g++) begin : g_tim
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           tim_q[g] <= '0;
            else if (bus_wr && sel == TIM_SEL[g]) tim_q[g] <= bus_wdata;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upb_q  <= '0;
         lpb_q  <= '0;
         ctrl_q <= '0;
      end else if (bus_wr) begin
         if (sel == SEL_UPB)  upb_q  <= bus_wdata;
         if (sel == SEL_LPB)  lpb_q  <= bus_wdata;
         if (sel == SEL_CTRL) ctrl_q <= bus_wdata;
      end
   end

   lcd_regs_irq #(.NEVT(NEVT)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .mask_we (bus_wr && sel == SEL_MASK),
      .clr_we  (bus_wr && sel == SEL_CLR),
      .wr_bits (bus_wdata[NEVT-1:0]),
      .evt_set (evt_set),
      .status  (status),
      .mask    (mask),
      .irq     (irq)
   );

   lcd_regs_geom u_geom (
      .tim0_ppl   (tim_q[0][7:2]),
      .tim1_lpp   (tim_q[1][9:0]),
      .ctrl_depth (ctrl_q[CTRL_DEPTH_LSB +: DEPTH_W]),
      .ctrl_en    (ctrl_q[CTRL_EN_BIT]),
      .ctrl_pwr   (ctrl_q[CTRL_PWR_BIT]),
      .cols       (cols),
      .rows       (rows),
      .depth      (depth),
      .disp_en    (disp_en)
   );

   assign pal_we    = bus_wr && sel == SEL_PAL;
   assign pal_re    = bus_rd && sel == SEL_PAL;
   assign pal_wdata = bus_wdata;

   always_comb begin
      case (sel)
         SEL_TIM0:  rd_d = tim_q[0];
         SEL_TIM1:  rd_d = tim_q[1];
         SEL_TIM2:  rd_d = tim_q[2];
         SEL_TIM3:  rd_d = tim_q[3];
         SEL_UPB, SEL_UPCUR: rd_d = upb_q;
         SEL_LPB, SEL_LPCUR: rd_d = lpb_q;
         SEL_MASK:  rd_d = DW'(mask);
         SEL_CTRL:  rd_d = ctrl_q;
         SEL_RAW:   rd_d = DW'(status);
         SEL_MSKD:  rd_d = DW'(status & mask);
         SEL_PAL:   rd_d = pal_rdata;
         SEL_ID:    rd_d = DW'(id_byte(VARIANT, id_idx));
         default:   rd_d = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_d;
   end

   always_comb begin
      case (sel)
         SEL_TIM0, SEL_TIM1, SEL_TIM2, SEL_TIM3, SEL_UPB, SEL_LPB,
         SEL_MASK, SEL_CTRL, SEL_CLR, SEL_PAL: writable = 1'b1;
         default:                              writable = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_changed <= 1'b0;
      else        cfg_changed <= bus_wr && writable;
   end

   p_unmapped_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && sel == SEL_NONE) |=> (bus_rdata == '0));

   p_id_no_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel == SEL_ID) |=> !cfg_changed);

   p_cfg_quiet_r14: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> !cfg_changed);

   p_cfg_ctrl_pulse_r14: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel == SEL_CTRL) |=> cfg_changed);

   p_ctrl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && sel == SEL_CTRL) |=> ($stable(disp_en) && $stable(depth)));

endmodule

// File: tb/test_lcd_regs.sv
`timescale 1ns/100ps
module test_lcd_regs;

   localparam int DW = 32;
   localparam int NEVT = 5;
   localparam logic [DW-1:0] PAL_VAL = 32'hCAFE_0123;

   typedef struct {
      bit          ext;
      logic [31:0] exp;
      string       tag;
   } rd_item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [NEVT-1:0] evt_set = '0;
   logic [DW-1:0] pal_rdata = PAL_VAL;

   logic [DW-1:0] rdata, rdata_x, pal_wdata, pal_wdata_x;
   logic irq, irq_x, pal_we, pal_we_x, pal_re, pal_re_x;
   logic [6:0] pal_idx, pal_idx_x;
   logic [10:0] cols, cols_x, rows, rows_x;
   logic [2:0] depth, depth_x;
   logic disp_en, disp_en_x, cfg_changed, cfg_changed_x;

   int total = 0;
   int bad = 0;
   bit rd_seen = 1'b0;
   rd_item_t rq[$];

   always #2.5 clk = ~clk;

   lcd_regs #(.DW(DW), .NEVT(NEVT), .VARIANT(0)) i_lcd_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata),
      .evt_set(evt_set), .irq(irq), .pal_we(pal_we), .pal_re(pal_re),
      .pal_idx(pal_idx), .pal_wdata(pal_wdata), .pal_rdata(pal_rdata),
      .cols(cols), .rows(rows), .depth(depth), .disp_en(disp_en),
      .cfg_changed(cfg_changed));

   lcd_regs #(.DW(DW), .NEVT(NEVT), .VARIANT(2)) i_lcd_regs_ext (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_x),
      .evt_set(evt_set), .irq(irq_x), .pal_we(pal_we_x), .pal_re(pal_re_x),
      .pal_idx(pal_idx_x), .pal_wdata(pal_wdata_x), .pal_rdata(pal_rdata),
      .cols(cols_x), .rows(rows_x), .depth(depth_x), .disp_en(disp_en_x),
      .cfg_changed(cfg_changed_x));

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: a read strobed at edge N is compared at the falling edge after it
   always @(posedge clk) rd_seen <= bus_rd;

   always @(negedge clk) begin
      if (rd_seen) begin
         if (rq.size() == 0) begin
            total++; bad++;
            $display("FAIL R1: read result with no expectation actual=%h expected=none", rdata);
         end else begin
            rd_item_t it;
            it = rq.pop_front();
            chk(it.ext ? rdata_x : rdata, it.exp, it.tag);
         end
      end
   end

   task automatic rd(input logic [11:0] a, input logic [31:0] exp, input bit ext, input string tag);
      rd_item_t it;
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      it.ext = ext; it.exp = exp; it.tag = tag;
      rq.push_back(it);
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic pulse_evt(input logic [NEVT-1:0] v);
      @(negedge clk);
      evt_set = v;
      @(negedge clk);
      evt_set = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk(32'(cols), 32'd16, "R2 reset cols");
      chk(32'(rows), 32'd1, "R3 reset rows");
      chk(32'(disp_en), 32'd0, "R5 reset enable");
      chk(32'(irq), 32'd0, "R9 reset irq");
      chk(32'(cfg_changed), 32'd0, "R14 reset pulse");
      rd(12'h000, 32'h0, 1'b0, "R1 reset timing0");
      rd(12'h01C, 32'h0, 1'b0, "R1 reset control");

      // geometry
      wr(12'h000, 32'h0000_0013);
      chk(32'(cfg_changed), 32'd1, "R14 pulse after timing write");
      chk(32'(cols), 32'd80, "R2 cols field 0x10");
      @(negedge clk);
      chk(32'(cfg_changed), 32'd0, "R14 pulse lasts one cycle");
      wr(12'h000, 32'hFFFF_FFFF);
      chk(32'(cols), 32'd1024, "R2 cols max");
      rd(12'h000, 32'hFFFF_FFFF, 1'b0, "R1 timing0 readback");
      wr(12'h004, 32'h0000_01DF);
      chk(32'(rows), 32'd480, "R3 rows 480");
      wr(12'h004, 32'hFFFF_FC00);
      chk(32'(rows), 32'd1, "R3 rows field masked to zero");
      wr(12'h004, 32'h0000_07FF);
      chk(32'(rows), 32'd1024, "R3 rows max");

      wr(12'h008, 32'h1234_5678);
      wr(12'h00C, 32'h9ABC_DEF0);
      wr(12'h010, 32'h8000_0000);
      wr(12'h014, 32'h4000_1000);
      rd(12'h008, 32'h1234_5678, 1'b0, "R1 timing2");
      rd(12'h00C, 32'h9ABC_DEF0, 1'b0, "R1 timing3");
      rd(12'h010, 32'h8000_0000, 1'b0, "R1 upper base");
      rd(12'h014, 32'h4000_1000, 1'b0, "R1 lower base");
      rd(12'h004, 32'h0000_07FF, 1'b0, "R1 timing1");
      rd(12'h02C, 32'h8000_0000, 1'b0, "R10 current upper");
      rd(12'h030, 32'h4000_1000, 1'b0, "R10 current lower");
      rd(12'h010, 32'h8000_0000, 1'b1, "R1 ext upper base");

      // control and variant swap
      wr(12'h01C, 32'h0000_080B);
      chk(32'(depth), 32'd5, "R4 depth 5");
      chk(32'(disp_en), 32'd1, "R5 enable with power");
      chk(32'(disp_en_x), 32'd0, "R6 ext 0x1C is mask");
      rd(12'h01C, 32'h0000_080B, 1'b0, "R6 base control at 0x1C");
      rd(12'h01C, 32'h0000_000B, 1'b1, "R6 ext mask at 0x1C");
      wr(12'h01C, 32'h0000_000B);
      chk(32'(disp_en), 32'd0, "R5 no power no enable");
      wr(12'h01C, 32'h0000_0801);
      chk(32'(disp_en), 32'd1, "R5 enable bit plus power");
      chk(32'(depth), 32'd0, "R4 depth 0");
      wr(12'h01C, 32'h0000_0800);
      chk(32'(disp_en), 32'd0, "R5 power without enable bit");
      wr(12'h018, 32'h0000_0801);
      chk(32'(disp_en_x), 32'd1, "R6 ext control at 0x18");
      rd(12'h018, 32'h0000_0001, 1'b0, "R6 base mask at 0x18");
      rd(12'h018, 32'h0000_0801, 1'b1, "R6 ext control readback");

      // status, mask, clear
      pulse_evt(5'b00110);
      chk(32'(irq), 32'd0, "R9 unmasked events no irq");
      rd(12'h020, 32'h0000_0006, 1'b0, "R7 raw status");
      rd(12'h024, 32'h0000_0000, 1'b0, "R7 masked status empty");
      wr(12'h018, 32'h0000_0004);
      chk(32'(irq), 32'd1, "R9 irq on masked bit");
      rd(12'h024, 32'h0000_0004, 1'b0, "R7 masked status");
      wr(12'h028, 32'h0000_0004);
      chk(32'(irq), 32'd0, "R8 clear drops irq");
      chk(32'(cfg_changed), 32'd1, "R14 pulse after clear write");
      rd(12'h020, 32'h0000_0002, 1'b0, "R8 partial clear");
      @(negedge clk);
      bus_addr = 12'h028; bus_wdata = 32'h0000_0002; bus_wr = 1'b1; evt_set = 5'b00010;
      @(negedge clk);
      bus_wr = 1'b0; evt_set = '0;
      rd(12'h020, 32'h0000_0002, 1'b0, "R8 set wins over clear");
      wr(12'h028, 32'hFFFF_FFFF);
      rd(12'h020, 32'h0000_0000, 1'b0, "R8 clear all");

      // identification
      for (int i = 0; i < 8; i++) begin
         logic [7:0] b, bx;
         case (i)
            0: begin b = 8'h10; bx = 8'h11; end
            1: begin b = 8'h11; bx = 8'h11; end
            2: begin b = 8'h04; bx = 8'h24; end
            3: begin b = 8'h00; bx = 8'h00; end
            4: begin b = 8'h0D; bx = 8'h0D; end
            5: begin b = 8'hF0; bx = 8'hF0; end
            6: begin b = 8'h05; bx = 8'h05; end
            default: begin b = 8'hB1; bx = 8'hB1; end
         endcase
         rd(12'hFE0 + 12'(4*i), 32'(b), 1'b0, "R11 base id byte");
         rd(12'hFE0 + 12'(4*i), 32'(bx), 1'b1, "R11 ext id byte");
      end

      // unmapped
      rd(12'h034, 32'h0, 1'b0, "R12 read 0x34");
      rd(12'h100, 32'h0, 1'b0, "R12 read 0x100");
      rd(12'h028, 32'h0, 1'b0, "R12 read clear offset");
      rd(12'h1FC, 32'h0, 1'b0, "R12 read below palette");
      rd(12'h400, 32'h0, 1'b0, "R12 read above palette");
      wr(12'h034, 32'hDEAD_BEEF);
      chk(32'(cfg_changed), 32'd0, "R12 unmapped write no pulse");
      wr(12'hFE0, 32'hDEAD_BEEF);
      chk(32'(cfg_changed), 32'd0, "R12 id write no pulse");
      chk(32'(cols), 32'd1024, "R12 cols untouched");
      rd(12'h010, 32'h8000_0000, 1'b0, "R12 upper base untouched");
      rd(12'hFE0, 32'h10, 1'b0, "R12 id untouched");

      // palette forwarding
      @(negedge clk);
      bus_addr = 12'h204; bus_wdata = 32'h0000_0055; bus_wr = 1'b1;
      #1;
      chk(32'(pal_we), 32'd1, "R13 palette write strobe");
      chk(32'(pal_re), 32'd0, "R13 no palette read strobe");
      chk(32'(pal_idx), 32'd1, "R13 palette index");
      chk(pal_wdata, 32'h0000_0055, "R13 palette data");
      @(negedge clk);
      bus_wr = 1'b0;
      chk(32'(cfg_changed), 32'd1, "R14 pulse after palette write");
      @(negedge clk);
      bus_addr = 12'h3FC; bus_rd = 1'b1;
      #1;
      chk(32'(pal_re), 32'd1, "R13 palette read strobe");
      chk(32'(pal_idx), 32'd127, "R13 last palette index");
      begin
         rd_item_t it;
         it.ext = 1'b0; it.exp = PAL_VAL; it.tag = "R13 palette read data";
         rq.push_back(it);
      end
      @(negedge clk);
      bus_rd = 1'b0;
      rd(12'h200, PAL_VAL, 1'b1, "R13 ext palette read data");

      repeat (3) @(negedge clk);
      chk(32'(rq.size()), 32'd0, "R1 all reads returned");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule